// File: doc/BRIEF.md
# Auto-Reload Decrementer Timer

This block is a software-programmable down-counter that ticks at the time-base rate. Each time-base strobe lowers the count by one. The tick that takes the count from one to zero records a sticky timeout flag. From that flag, and an enable bit, the block drives a level interrupt. The block is used as a general-purpose software timer: software loads a count, and the timer flags when that amount of time has elapsed.

The counter cannot be stopped and runs whenever the clock runs. Software may overwrite it at any moment, and that write wins over a tick in the same cycle. A separate reload register, gated by a control bit, can refill the counter on the terminal tick. This gives a periodic timer with no software involvement between periods. Writing the reload register never disturbs the running count.

Top module: `dec_timer`

## Requirements
- R1: After reset the count, the reload value, both control bits and the status flag are all 0, so `count_o`, `status_o` and `irq_o` read 0.
- R2: A count write (`cnt_wr_i`) loads `cnt_wdata_i`, which is visible on `count_o` in the next cycle. This holds at any time. A tick in the same cycle is discarded.
- R3: A tick with no count write decrements a count above 1 by exactly one. Without a tick or a write, the count is unchanged.
- R4: A tick at count 1 sets the status flag. With reload disabled, the count becomes 0 and then holds at 0 under further ticks, raising no further events.
- R5: With reload enabled (control bit 1), a tick at count 1 loads the reload register into the count instead of 0, and still sets the status flag.
- R6: A reload register write (`rld_wr_i`) never changes the running count. It affects only the next reload.
- R7: The status flag is sticky. A status write with data 1 clears it. A status write with data 0 has no effect. If a terminal tick and a clear occur in the same cycle, the flag ends up set.
- R8: `irq_o` is high exactly when the status flag is set and the interrupt enable (control bit 0) is 1. It follows both without added delay.
- R9: A control write (`ctl_wr_i`) updates both enables from `ctl_wdata_i` (bit 0 interrupt enable, bit 1 reload enable). The new values take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time-base tick strobe |
| cnt_wr_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | W | Count write data |
| rld_wr_i | input | 1 | Reload register write strobe |
| rld_wdata_i | input | W | Reload register write data |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 2 | Control data: bit 0 interrupt enable, bit 1 reload enable |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 1 | Status write data, 1 clears |
| count_o | output | W | Current count |
| status_o | output | 1 | Sticky timeout flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Random traffic uses dense ticks with small written counts and reload values. This drives the counter through zero many times, in both one-shot and periodic modes. It also exposes reload-versus-zero and hold-at-zero differences. Writes to the count, reload register, control and status land on random cycles, often together with a tick, to separate write priority from decrement. Directed cases cover the boundary events: a write and a tick together, a clear racing a terminal tick, a clear with data 0, a reload write mid-count, and interrupt masking while the flag is set.

// File: rtl/dec_timer_pkg.sv
`timescale 1ns/1ps
package dec_timer_pkg;
  localparam int CTL_W = 2;
  // bit 1: reload enable, bit 0: interrupt enable
  typedef struct packed {
    logic rld_en;
    logic irq_en;
  } ctl_t;
endpackage

// File: rtl/dec_count_reg.sv
`timescale 1ns/1ps
module dec_count_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rld_en_i,
  input  logic [W-1:0] rld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_evt_o
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  function automatic logic f_terminal(input logic [W-1:0] c);
    return c == ONE;
  endfunction

  function automatic logic [W-1:0] f_after_tick(input logic [W-1:0] c,
                                                input logic rld_en,
                                                input logic [W-1:0] rld);
    if (c == ZERO)        return ZERO;
    else if (f_terminal(c)) return rld_en ? rld : ZERO;
    else                  return c - ONE;
  endfunction

  logic [W-1:0] cnt_q, cnt_d;
  logic         tick_eff;

  assign tick_eff   = tick_i & ~wr_i;
  assign zero_evt_o = tick_eff & f_terminal(cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)          cnt_d = wdata_i;
    else if (tick_eff) cnt_d = f_after_tick(cnt_q, rld_en_i, rld_val_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= ZERO;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dec_cfg_regs.sv
`timescale 1ns/1ps
module dec_cfg_regs
  import dec_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rld_wr_i,
  input  logic [W-1:0]     rld_wdata_i,
  input  logic             ctl_wr_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [W-1:0]     rld_val_o,
  output ctl_t             ctl_o
);
  logic [W-1:0] rld_q;
  ctl_t         ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld_q <= '0;
      ctl_q <= '0;
    end else begin
      if (rld_wr_i) rld_q <= rld_wdata_i;
      if (ctl_wr_i) ctl_q <= ctl_t'(ctl_wdata_i);
    end
  end

  assign rld_val_o = rld_q;
  assign ctl_o     = ctl_q;
endmodule

// File: rtl/dec_status.sv
`timescale 1ns/1ps
module dec_status (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_evt_i,
  input  logic clr_wr_i,
  input  logic clr_data_i,
  input  logic irq_en_i,
  output logic status_o,
  output logic irq_o
);
  logic sts_q;
  logic clr_req;

  assign clr_req = clr_wr_i & clr_data_i;

  // a new event beats a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)          sts_q <= 1'b0;
    else if (zero_evt_i) sts_q <= 1'b1;
    else if (clr_req)    sts_q <= 1'b0;
  end

  assign status_o = sts_q;
  assign irq_o    = sts_q & irq_en_i;
endmodule

// File: rtl/dec_timer.sv
`timescale 1ns/1ps
module dec_timer
  import dec_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic         rld_wr_i,
  input  logic [W-1:0] rld_wdata_i,
  input  logic         ctl_wr_i,
  input  logic [1:0]   ctl_wdata_i,
  input  logic         sts_wr_i,
  input  logic         sts_wdata_i,
  output logic [W-1:0] count_o,
  output logic         status_o,
  output logic         irq_o
);
  logic [W-1:0] rld_val;
  ctl_t         ctl;
  logic         zero_evt;

  dec_cfg_regs #(.W(W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .rld_wr_i   (rld_wr_i),
    .rld_wdata_i(rld_wdata_i),
    .ctl_wr_i   (ctl_wr_i),
    .ctl_wdata_i(ctl_wdata_i),
    .rld_val_o  (rld_val),
    .ctl_o      (ctl)
  );

  dec_count_reg #(.W(W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_i      (cnt_wr_i),
    .wdata_i   (cnt_wdata_i),
    .rld_en_i  (ctl.rld_en),
    .rld_val_i (rld_val),
    .cnt_o     (count_o),
    .zero_evt_o(zero_evt)
  );

  dec_status u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .zero_evt_i(zero_evt),
    .clr_wr_i  (sts_wr_i),
    .clr_data_i(sts_wdata_i),
    .irq_en_i  (ctl.irq_en),
    .status_o  (status_o),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/dec_timer_chk.sv
`timescale 1ns/1ps
module dec_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_i,
  input logic         cnt_wr_i,
  input logic [W-1:0] cnt_wdata_i,
  input logic         rld_wr_i,
  input logic         sts_wr_i,
  input logic         sts_wdata_i,
  input logic [W-1:0] count_o,
  input logic         status_o,
  input logic         zero_evt,
  input logic         rld_en,
  input logic [W-1:0] rld_val
);
  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> count_o == $past(cnt_wdata_i));

  a_r3_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cnt_wr_i && count_o > W'(1)) |=> count_o == $past(count_o) - W'(1));

  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !cnt_wr_i) |=> $stable(count_o));

  a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == '0 && !cnt_wr_i) |=> count_o == '0);

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && rld_en) |=> count_o == $past(rld_val));

  a_r6_reload_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_wr_i && !tick_i && !cnt_wr_i) |=> $stable(count_o));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o && !(sts_wr_i && sts_wdata_i)) |=> status_o);

  a_r7_set_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o) |-> $past(zero_evt));
endmodule

bind dec_timer dec_timer_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .cnt_wr_i   (cnt_wr_i),
  .cnt_wdata_i(cnt_wdata_i),
  .rld_wr_i   (rld_wr_i),
  .sts_wr_i   (sts_wr_i),
  .sts_wdata_i(sts_wdata_i),
  .count_o    (count_o),
  .status_o   (status_o),
  .zero_evt   (zero_evt),
  .rld_en     (ctl.rld_en),
  .rld_val    (rld_val)
);

// File: tb/test_dec_timer.sv
`timescale 1ns/1ps
module test_dec_timer;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 0, cnt_wr_i = 0, rld_wr_i = 0, ctl_wr_i = 0, sts_wr_i = 0, sts_wdata_i = 0;
  logic [W-1:0] cnt_wdata_i = '0, rld_wdata_i = '0;
  logic [1:0] ctl_wdata_i = '0;
  logic [W-1:0] count_o;
  logic status_o, irq_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dec_timer #(.W(W)) i_dec_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
    .rld_wr_i(rld_wr_i), .rld_wdata_i(rld_wdata_i),
    .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
    .sts_wr_i(sts_wr_i), .sts_wdata_i(sts_wdata_i),
    .count_o(count_o), .status_o(status_o), .irq_o(irq_o)
  );

  // reference model
  logic [W-1:0] m_cnt = '0, m_rld = '0;
  logic m_ie = 0, m_re = 0, m_sts = 0;

  function automatic logic [W-1:0] ref_count(logic [W-1:0] c, logic t, logic w,
                                             logic [W-1:0] wd, logic re, logic [W-1:0] rl);
    if (w) return wd;
    if (!t) return c;
    case (c)
      W'(0):   return W'(0);
      W'(1):   return re ? rl : W'(0);
      default: return c - W'(1);
    endcase
  endfunction

  function automatic logic ref_status(logic s, logic [W-1:0] c, logic t, logic w,
                                      logic sw, logic sd);
    logic hit;
    hit = t && !w && c == W'(1);
    return hit | (s & ~(sw & sd));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0; m_rld <= '0; m_ie <= 0; m_re <= 0; m_sts <= 0;
    end else begin
      m_cnt <= ref_count(m_cnt, tick_i, cnt_wr_i, cnt_wdata_i, m_re, m_rld);
      m_sts <= ref_status(m_sts, m_cnt, tick_i, cnt_wr_i, sts_wr_i, sts_wdata_i);
      if (rld_wr_i) m_rld <= rld_wdata_i;
      if (ctl_wr_i) begin m_ie <= ctl_wdata_i[0]; m_re <= ctl_wdata_i[1]; end
    end
  end

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // apply inputs for one cycle (called at a negedge), return at the next negedge
  task automatic step(logic t, logic cw, logic [W-1:0] cd, logic rw, logic [W-1:0] rd,
                      logic kw, logic [1:0] kd, logic sw, logic sd);
    tick_i = t; cnt_wr_i = cw; cnt_wdata_i = cd; rld_wr_i = rw; rld_wdata_i = rd;
    ctl_wr_i = kw; ctl_wdata_i = kd; sts_wr_i = sw; sts_wdata_i = sd;
    @(posedge clk);
    @(negedge clk);
    tick_i = 0; cnt_wr_i = 0; rld_wr_i = 0; ctl_wr_i = 0; sts_wr_i = 0; sts_wdata_i = 0;
    chk("R3", "model count", count_o, m_cnt);
    chk("R7", "model status", W'(status_o), W'(m_sts));
    chk("R8", "model irq", W'(irq_o), W'(m_sts & m_ie));
  endtask

  task automatic tk(); step(1, 0, '0, 0, '0, 0, 2'b00, 0, 0); endtask
  task automatic wcnt(logic [W-1:0] v); step(0, 1, v, 0, '0, 0, 2'b00, 0, 0); endtask
  task automatic wctl(logic [1:0] v); step(0, 0, '0, 0, '0, 1, v, 0, 0); endtask
  task automatic clr(); step(0, 0, '0, 0, '0, 0, 2'b00, 1, 1); endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1", "count after reset", count_o, '0);
    chk("R1", "status after reset", W'(status_o), '0);
    chk("R1", "irq after reset", W'(irq_o), '0);
    tk();
    chk("R1", "count holds 0 after reset tick", count_o, '0);

    // R2 write beats tick
    step(1, 1, W'(5), 0, '0, 0, 2'b00, 0, 0);
    chk("R2", "write with tick", count_o, W'(5));
    wcnt(W'(32'hFFFF_FFF0));
    chk("R2", "large write", count_o, W'(32'hFFFF_FFF0));

    // R3 decrement and idle
    tk();
    chk("R3", "decrement", count_o, W'(32'hFFFF_FFEF));
    step(0, 0, '0, 0, '0, 0, 2'b00, 0, 0);
    chk("R3", "idle no change", count_o, W'(32'hFFFF_FFEF));

    // R4 one-shot terminal and hold
    wcnt(W'(2));
    tk();
    chk("R4", "count 1", count_o, W'(1));
    chk("R4", "no flag before zero", W'(status_o), '0);
    tk();
    chk("R4", "count reaches 0", count_o, '0);
    chk("R4", "flag set", W'(status_o), W'(1));
    clr();
    chk("R7", "clear with 1", W'(status_o), '0);
    repeat (3) tk();
    chk("R4", "holds at 0", count_o, '0);
    chk("R4", "no further event", W'(status_o), '0);

    // R9 and R5 periodic reload
    step(0, 0, '0, 1, W'(7), 0, 2'b00, 0, 0);
    wctl(2'b10);
    wcnt(W'(1));
    tk();
    chk("R5", "reloaded", count_o, W'(7));
    chk("R5", "flag set on reload", W'(status_o), W'(1));
    chk("R9", "irq masked while ie=0", W'(irq_o), '0);
    wctl(2'b11);
    chk("R8", "irq with ie=1", W'(irq_o), W'(1));

    // R7 clear with 0 ignored
    step(0, 0, '0, 0, '0, 0, 2'b00, 1, 0);
    chk("R7", "clear data 0 ignored", W'(status_o), W'(1));
    clr();
    chk("R8", "irq drops with flag", W'(irq_o), '0);

    // R6 reload write mid-count
    step(0, 0, '0, 1, W'(3), 0, 2'b00, 0, 0);
    chk("R6", "count untouched by reload write", count_o, W'(7));
    repeat (6) tk();
    chk("R6", "count at 1", count_o, W'(1));
    tk();
    chk("R6", "new reload used", count_o, W'(3));

    // R7 clear races terminal tick
    clr();
    wcnt(W'(1));
    step(1, 0, '0, 0, '0, 0, 2'b00, 1, 1);
    chk("R7", "set wins over clear", W'(status_o), W'(1));

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic t, cw, rw, kw, sw, sd;
      t  = ($urandom % 4) != 0;
      cw = ($urandom % 23) == 0;
      rw = ($urandom % 17) == 0;
      kw = ($urandom % 29) == 0;
      sw = ($urandom % 7) == 0;
      sd = $urandom % 2;
      step(t, cw, W'($urandom % 20), rw, W'($urandom % 10), kw, 2'($urandom), sw, sd);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule